// File: doc/BRIEF.md
# MDIO Management Master

This block is a memory-mapped controller that carries out single read or write accesses to PHY management registers over the two-wire MDC/MDIO interface. Software fills a command register with the PHY address, the register number and an opcode bit. For writes it also loads a 16-bit write-data register. It then sets the go bit in the control register, provided the enable bit in the same write is 1.

Once started, the block builds a 64-bit management frame and shifts it out one bit per MDC period. It releases the data line for the turnaround and data phase of a read, and shifts in the reply. The go bit doubles as the busy flag. Hardware clears it on the final MDC falling edge. The read-data register is updated on that same clock edge.

MDC runs only while a frame is in flight. Its rate is the system clock divided by twice the `DIV_HALF` parameter.

Top module: `mdio_master`

## Requirements
- R1: The command register (byte offset 0x7E4) holds the register number in bits [4:0], the PHY address in bits [9:5] and the opcode in bit 10, where 1 means read and 0 means write; these fields appear unchanged in the frame.
- R2: The write-data register (0x7E8) and the read-data register (0x7EC) keep only bits [15:0], and their upper 16 bits read as zero.
- R3: Writing control (0x7F0) with bit 0 set and bit 3 set starts a frame. Bit 0 then reads 1 until hardware clears it, exactly 128*DIV_HALF system cycles after the write edge.
- R4: Control bit 3 is an enable that reads back as written. A write with bit 0 set and bit 3 clear starts nothing.
- R5: The four registers decode at byte offsets 0x7E4, 0x7E8, 0x7EC and 0x7F0, and any other offset reads zero.
- R6: For a read, the captured 16-bit value is in the read-data register in the same cycle that the busy bit clears.
- R7: A frame is, MSB first: 32 ones, start 01, opcode (10 read, 01 write), PHY address, register number, turnaround (10 on writes), and 16 data bits.
- R8: MDC has a period of 2*DIV_HALF system cycles while busy. When idle, MDC is low and the output enable is low.
- R9: MDIO output changes only together with a falling edge of MDC, and read data is sampled on MDC rising edges.
- R10: During a read, the output enable is high for the first 46 bits and low for the turnaround and the 16 data bits; during a write it is high for all 64 bits.
- R11: A go request while busy is ignored, and writes to the command or write-data register during a frame do not change the frame in progress.
- R12: A read from a PHY that does not answer, with the line pulled high, returns 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register byte offset for both reads and writes |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i (combinational) |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe_o | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in |

## Verification
The bench contains a PHY model that answers at one address and stores what is written to it. If read data were sampled on the wrong MDC edge or latched one cycle late, the result would differ from the stored value or would still be stale when busy drops. A go write without the enable bit checks that no MDC edges appear. A second go write and new command and data values placed in the middle of a frame check that the captured frame still matches the original command and that busy lasts the nominal time. A read from an absent address must return all ones, which only holds if the line stays released through the data phase.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int unsigned FRAME_BITS = 64;
  localparam int unsigned PRE_BITS   = 32;
  localparam int unsigned HDR_BITS   = 46;  // driven bits on a read
  localparam int unsigned DATA_BITS  = 16;
  localparam int unsigned FIELD_W    = 5;
  localparam int unsigned GO_BIT     = 0;
  localparam int unsigned EN_BIT     = 3;

  localparam logic [11:0] OFS_CMD   = 12'h7E4;
  localparam logic [11:0] OFS_WDATA = 12'h7E8;
  localparam logic [11:0] OFS_RDATA = 12'h7EC;
  localparam logic [11:0] OFS_CTRL  = 12'h7F0;

  typedef enum logic [1:0] {
    OPC_WR = 2'b01,
    OPC_RD = 2'b10
  } mdio_opc_e;

  typedef struct packed {
    logic               rd;
    logic [FIELD_W-1:0] phy;
    logic [FIELD_W-1:0] regn;
  } mdio_cmd_t;

  function automatic logic [FRAME_BITS-1:0] build_frame(input mdio_cmd_t cmd,
                                                        input logic [DATA_BITS-1:0] wd);
    mdio_opc_e opc;
    logic [1:0] ta;
    logic [DATA_BITS-1:0] body;
    opc  = cmd.rd ? OPC_RD : OPC_WR;
    ta   = cmd.rd ? 2'b11 : 2'b10;
    body = cmd.rd ? {DATA_BITS{1'b1}} : wd;
    return {{PRE_BITS{1'b1}}, 2'b01, opc, cmd.phy, cmd.regn, ta, body};
  endfunction
endpackage

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv #(
  parameter int unsigned DIV_HALF = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic mdc_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int unsigned CNT_W = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DIV_HALF - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             mdc_q;
  logic             term;

  assign term = (cnt_q == CNT_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (!en_i) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (term) begin
      cnt_q <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign mdc_o  = mdc_q;
  assign rise_o = en_i & term & ~mdc_q;
  assign fall_o = en_i & term &  mdc_q;
endmodule

// File: rtl/mdio_shifter.sv
module mdio_shifter
  import mdio_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  mdio_cmd_t            cmd_i,
  input  logic [DATA_BITS-1:0] wdata_i,
  input  logic                 rise_i,
  input  logic                 fall_i,
  input  logic                 mdio_i,
  output logic                 busy_o,
  output logic                 mdio_o,
  output logic                 mdio_oe_o,
  output logic                 rd_done_o,
  output logic [DATA_BITS-1:0] rd_data_o
);
  localparam int unsigned IDX_W = $clog2(FRAME_BITS);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(FRAME_BITS - 1);
  localparam logic [IDX_W-1:0] IDX_HDR  = IDX_W'(HDR_BITS);
  localparam logic [IDX_W-1:0] IDX_DATA = IDX_W'(FRAME_BITS - DATA_BITS);

  logic                  busy_q;
  logic                  rd_q;
  logic [IDX_W-1:0]      idx_q;
  logic [FRAME_BITS-1:0] sh_q;
  logic [DATA_BITS-1:0]  cap_q;
  logic                  last;

  assign last = (idx_q == IDX_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      rd_q   <= 1'b0;
      idx_q  <= '0;
      sh_q   <= '1;
      cap_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      rd_q   <= cmd_i.rd;
      idx_q  <= '0;
      sh_q   <= build_frame(cmd_i, wdata_i);
    end else if (busy_q) begin
      if (rise_i && rd_q && idx_q >= IDX_DATA)
        cap_q <= {cap_q[DATA_BITS-2:0], mdio_i};
      if (fall_i) begin
        if (last) begin
          busy_q <= 1'b0;
          sh_q   <= '1;
        end else begin
          idx_q <= idx_q + 1'b1;
          sh_q  <= {sh_q[FRAME_BITS-2:0], 1'b1};
        end
      end
    end
  end

  assign busy_o    = busy_q;
  assign mdio_o    = sh_q[FRAME_BITS-1];
  assign mdio_oe_o = busy_q & (~rd_q | (idx_q < IDX_HDR));
  assign rd_done_o = busy_q & fall_i & last & rd_q;
  assign rd_data_o = cap_q;
endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
  import mdio_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [31:0]          wdata_i,
  output logic [31:0]          rdata_o,
  input  logic                 busy_i,
  input  logic                 rd_done_i,
  input  logic [DATA_BITS-1:0] rd_data_i,
  output mdio_cmd_t            cmd_o,
  output logic [DATA_BITS-1:0] wd_o,
  output logic                 start_o
);
  localparam int unsigned CMD_W = $bits(mdio_cmd_t);

  mdio_cmd_t            cmd_q;
  logic [DATA_BITS-1:0] wd_q;
  logic [DATA_BITS-1:0] rd_q;
  logic                 en_q;
  logic hit_cmd, hit_wd, hit_rd, hit_ctrl;

  assign hit_cmd  = (addr_i == ADDR_W'(OFS_CMD));
  assign hit_wd   = (addr_i == ADDR_W'(OFS_WDATA));
  assign hit_rd   = (addr_i == ADDR_W'(OFS_RDATA));
  assign hit_ctrl = (addr_i == ADDR_W'(OFS_CTRL));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q <= '0;
      wd_q  <= '0;
      rd_q  <= '0;
      en_q  <= 1'b0;
    end else begin
      if (wr_i && hit_cmd)  cmd_q <= mdio_cmd_t'(wdata_i[CMD_W-1:0]);
      if (wr_i && hit_wd)   wd_q  <= wdata_i[DATA_BITS-1:0];
      if (wr_i && hit_ctrl) en_q  <= wdata_i[EN_BIT];
      if (rd_done_i)        rd_q  <= rd_data_i;
    end
  end

  assign start_o = wr_i & hit_ctrl & wdata_i[GO_BIT] & wdata_i[EN_BIT] & ~busy_i;

  always_comb begin
    rdata_o = '0;
    if (hit_cmd)  rdata_o[CMD_W-1:0]     = cmd_q;
    if (hit_wd)   rdata_o[DATA_BITS-1:0] = wd_q;
    if (hit_rd)   rdata_o[DATA_BITS-1:0] = rd_q;
    if (hit_ctrl) begin
      rdata_o[GO_BIT] = busy_i;
      rdata_o[EN_BIT] = en_q;
    end
  end

  assign cmd_o = cmd_q;
  assign wd_o  = wd_q;
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned DIV_HALF = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              mdc_o,
  output logic              mdio_o,
  output logic              mdio_oe_o,
  input  logic              mdio_i
);
  mdio_cmd_t            cmd;
  logic [DATA_BITS-1:0] wd;
  logic [DATA_BITS-1:0] rd_data;
  logic                 start, busy, rd_done, rise, fall;

  mdio_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (reg_wr_i),
    .addr_i   (reg_addr_i),
    .wdata_i  (reg_wdata_i),
    .rdata_o  (reg_rdata_o),
    .busy_i   (busy),
    .rd_done_i(rd_done),
    .rd_data_i(rd_data),
    .cmd_o    (cmd),
    .wd_o     (wd),
    .start_o  (start)
  );

  mdio_clkdiv #(.DIV_HALF(DIV_HALF)) u_div (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (busy),
    .mdc_o (mdc_o),
    .rise_o(rise),
    .fall_o(fall)
  );

  mdio_shifter u_shift (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start),
    .cmd_i    (cmd),
    .wdata_i  (wd),
    .rise_i   (rise),
    .fall_i   (fall),
    .mdio_i   (mdio_i),
    .busy_o   (busy),
    .mdio_o   (mdio_o),
    .mdio_oe_o(mdio_oe_o),
    .rd_done_o(rd_done),
    .rd_data_o(rd_data)
  );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk
  import mdio_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_i,
  input logic              reg_wr_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic [31:0]       reg_wdata_i,
  input logic [31:0]       reg_rdata_o,
  input logic              mdc_o,
  input logic              mdio_o,
  input logic              mdio_oe_o
);
  p_idle_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> (!mdc_o && !mdio_oe_o));

  p_mdio_on_fall_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && $past(busy_i) && !$fell(mdc_o)) |-> $stable(mdio_o));

  p_release_holds_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && $past(busy_i) && !$past(mdio_oe_o)) |-> !mdio_oe_o);

  p_start_needs_en_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> $past(reg_wr_i && reg_addr_i == ADDR_W'(OFS_CTRL)
                            && reg_wdata_i[EN_BIT] && reg_wdata_i[GO_BIT]));

  p_rdata_only_at_end_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($stable(reg_addr_i) && reg_addr_i == ADDR_W'(OFS_RDATA) && !$fell(busy_i))
      |-> $stable(reg_rdata_o));
endmodule

bind mdio_master mdio_master_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .busy_i     (busy),
  .reg_wr_i   (reg_wr_i),
  .reg_addr_i (reg_addr_i),
  .reg_wdata_i(reg_wdata_i),
  .reg_rdata_o(reg_rdata_o),
  .mdc_o      (mdc_o),
  .mdio_o     (mdio_o),
  .mdio_oe_o  (mdio_oe_o)
);

// File: tb/mdio_master_bench.sv
module mdio_master_bench;
  localparam int DH = 2;
  localparam int FRAME_CYC = 128 * DH;
  localparam logic [4:0] MY_PHY = 5'd1;
  localparam logic [11:0] A_CMD = 12'h7E4, A_WD = 12'h7E8, A_RD = 12'h7EC, A_CTRL = 12'h7F0;
  // {rd, phy, reg, data or expected read}
  localparam int NV = 8;
  localparam logic [26:0] VEC [NV] = '{
    {1'b0, 5'd1,  5'd3,  16'h1234},
    {1'b1, 5'd1,  5'd3,  16'h1234},
    {1'b1, 5'd1,  5'd5,  16'hC305},
    {1'b1, 5'd9,  5'd3,  16'hFFFF},
    {1'b0, 5'd1,  5'd31, 16'hA55A},
    {1'b1, 5'd1,  5'd31, 16'hA55A},
    {1'b0, 5'd30, 5'd0,  16'h0F0F},
    {1'b1, 5'd1,  5'd0,  16'hC300}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic mdc, mdio_out, mdio_oe;
  logic mdio_in = 1'b1;

  int errs = 0, checks = 0, cyc = 0, start_cyc = 0;
  int bit_idx = 0, nrise = 0, rise_prev = 0, rise_last = 0;
  logic [63:0] cap_bits = '0, cap_oe = '0;
  logic [15:0] phy_mem [32];
  bit finished = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  mdio_master #(.ADDR_W(12), .DIV_HALF(DH)) u_mdio_master (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .mdc_o(mdc),
    .mdio_o(mdio_out), .mdio_oe_o(mdio_oe), .mdio_i(mdio_in));

  // PHY model: samples on MDC rise, drives on MDC fall
  always @(posedge mdc) begin
    nrise++;
    rise_prev = rise_last;
    rise_last = cyc;
    if (bit_idx < 64) begin
      cap_bits[63-bit_idx] = mdio_out;
      cap_oe[63-bit_idx]   = mdio_oe;
      if (bit_idx == 63 && cap_bits[29:28] == 2'b01 && cap_bits[27:23] == MY_PHY)
        phy_mem[cap_bits[22:18]] = cap_bits[15:0];
    end
    bit_idx++;
  end

  always @(negedge mdc) begin
    if (bit_idx >= 48 && bit_idx <= 63 && cap_bits[29:28] == 2'b10 && cap_bits[27:23] == MY_PHY)
      mdio_in = phy_mem[cap_bits[22:18]][63-bit_idx];
    else
      mdio_in = 1'b1;
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [11:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic go();
    bit_idx = 0;
    bus_wr(A_CTRL, 32'h9);
    start_cyc = cyc;
  endtask

  task automatic wait_idle(output int el);
    logic [31:0] v;
    forever begin
      bus_rd(A_CTRL, v);
      if (!v[0]) break;
      @(negedge clk);
    end
    el = cyc - start_cyc;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    int el, r0;
    for (int r = 0; r < 32; r++) phy_mem[r] = {8'hC3, 3'b000, 5'(r)};
    repeat (3) @(negedge clk);
    // reset state
    bus_rd(A_CTRL, v);  chk("R3 reset ctrl", 64'(v), 64'h0);
    bus_rd(A_RD, v);    chk("R2 reset rdata", 64'(v), 64'h0);
    chk("R8 reset pins", {62'b0, mdc, mdio_oe}, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R5 offsets and R2 widths
    bus_wr(A_CMD, 32'hFFFF_FFFF);  bus_rd(A_CMD, v); chk("R1 R5 cmd readback", 64'(v), 64'h7FF);
    bus_wr(A_WD, 32'hFFFF_ABCD);   bus_rd(A_WD, v);  chk("R2 R5 wdata readback", 64'(v), 64'hABCD);
    bus_rd(12'h7F4, v); chk("R5 unmapped", 64'(v), 64'h0);

    // R4 go without enable
    r0 = nrise;
    bus_wr(A_CTRL, 32'h1);
    repeat (20) @(negedge clk);
    bus_rd(A_CTRL, v); chk("R4 no start when disabled", 64'(v), 64'h0);
    chk("R4 no MDC when disabled", 64'(nrise - r0), 64'h0);
    bus_wr(A_CTRL, 32'h8); bus_rd(A_CTRL, v); chk("R4 enable readback", 64'(v), 64'h8);

    // vector table
    for (int i = 0; i < NV; i++) begin
      logic rd;
      logic [4:0] ph, rg;
      logic [15:0] dt;
      logic [63:0] ex, mk;
      {rd, ph, rg, dt} = VEC[i];
      bus_wr(A_CMD, {21'b0, rd, ph, rg});
      bus_wr(A_WD, {16'b0, dt});
      go();
      wait_idle(el);
      chk("R3 busy length", 64'(el), 64'(FRAME_CYC));
      bus_rd(A_CTRL, v); chk("R3 go bit cleared", 64'(v), 64'h8);
      if (i == 0) chk("R8 MDC period", 64'(rise_last - rise_prev), 64'(2 * DH));
      ex = {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), ph, rg, 2'b10, dt};
      mk = rd ? {{46{1'b1}}, 18'b0} : '1;
      chk("R10 output enable pattern", cap_oe, mk);
      chk("R7 frame bits", cap_bits & mk, ex & mk);
      chk("R1 header fields", 64'(cap_bits[29:18]), 64'(ex[29:18]));
      if (rd) begin
        bus_rd(A_RD, v);
        if (ph == MY_PHY) chk("R6 R9 read data", 64'(v), 64'(dt));
        else              chk("R12 absent PHY", 64'(v), 64'(dt));
      end
    end

    // R11 go and register writes while busy
    bus_wr(A_CMD, {21'b0, 1'b0, 5'd1, 5'd7});
    bus_wr(A_WD, 32'h0000_5A5A);
    go();
    repeat (40) @(negedge clk);
    bus_wr(A_CMD, {21'b0, 1'b1, 5'd2, 5'd9});
    bus_wr(A_WD, 32'h0000_FFFF);
    bus_wr(A_CTRL, 32'h9);
    wait_idle(el);
    chk("R11 busy not restarted", 64'(el), 64'(FRAME_CYC));
    chk("R11 frame undisturbed", cap_bits, {32'hFFFF_FFFF, 2'b01, 2'b01, 5'd1, 5'd7, 2'b10, 16'h5A5A});
    bus_rd(A_CMD, v); chk("R11 cmd write landed", 64'(v), 64'({1'b1, 5'd2, 5'd9}));
    // R6 readback of value just written to PHY
    bus_wr(A_CMD, {21'b0, 1'b1, 5'd1, 5'd7});
    go();
    wait_idle(el);
    bus_rd(A_RD, v); chk("R6 read after write", 64'(v), 64'h5A5A);
    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule